// File: doc/BRIEF.md
# Per-Lane Credit Tracker with Shared Pool

This block sits on the transmit side of a link and tracks how much buffer space the far-end receiver has free. The receiver keeps one buffer pool. That pool is split into a private allowance for each virtual lane and one common region that any lane may borrow from. Before a group of flits goes out on a lane, the transmitter asks the block for permission. The block answers in the same cycle. When it grants, it books the flits against the lane's private allowance first and takes any remainder from the common region.

Credits come back a few bits at a time. Each link transfer packet that arrives carries a 2-bit return field. Four such fields, taken in order, form one 8-bit return message. The message names a lane and a count of freed credits. Freed credits repay that lane's debt to the common region before they go back to its private allowance. Management can change a lane's private allowance while the link runs. The change waits until the lane has nothing outstanding.

Top module: `vl_credit_mgr`

## Requirements
- R1: After reset, every lane reports its full private allowance (default 4) on `req_ded_free`, `shared_free` equals the common-region size (default 16), no `cfg_pend` bit is set, and `gnt` is low.
- R2: A request for n flits (1 to 7) on a lane whose free private credit is at least n is granted in the same cycle. After the clock edge, that lane's free private credit is lower by n and `shared_free` is unchanged.
- R3: If a request asks for more than the lane's free private credit f, and n-f is at most `shared_free`, it is granted. The grant uses all f private credits and takes n-f from `shared_free`.
- R4: If n-f exceeds `shared_free`, `gnt` stays low and no credit count changes.
- R5: Credit-return pieces are taken only in cycles where `ltp_valid` is high. The first piece of a group forms message bits [7:6], the next [5:4], then [3:2], and the fourth [1:0]. Bits [7:3] give the lane and bits [2:0] give the count. The message takes effect at the clock edge that samples the fourth piece, and not before.
- R6: A returned count first refills the common region, up to the amount the lane has borrowed. Any remainder frees the lane's private credits. Any count beyond what the lane has in use is dropped.
- R7: A configuration write to a lane with no credits in use, and no grant to that lane in the same cycle, sets the lane's private allowance at that clock edge.
- R8: A configuration write to a busy lane leaves the old allowance in place and sets the lane's `cfg_pend` bit. The new value takes effect, and `cfg_pend` clears, at the first clock edge where that lane has nothing in use.
- R9: A grant and a return on the same lane in the same cycle are both applied. The return is worked out from the counts held before that edge.
- R10: A grant or return on one lane leaves every other lane's private credit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Send request present |
| req_vl | input | 5 | Lane of the request; also selects the lane shown on `req_ded_free` |
| req_flits | input | 3 | Number of flits requested |
| gnt | output | 1 | Request granted (combinational) |
| req_ded_free | output | 8 | Free private credit of lane `req_vl` |
| shared_free | output | 10 | Free credit in the common region |
| ltp_valid | input | 1 | A transfer packet arrived this cycle |
| ltp_crd | input | 2 | Credit-return piece carried by that packet |
| cfg_valid | input | 1 | Private-allowance write |
| cfg_vl | input | 5 | Lane being configured |
| cfg_ded | input | 8 | New private allowance |
| cfg_pend | output | 32 | One bit per lane: write waiting for the lane to drain |

## Verification
The bench drives lanes into the common region and then returns credit in pieces that straddle the borrowed amount. A design that refilled private credit first would leave `shared_free` too low and the private count too high. Over-returns check that excess credit is dropped; a design without the clamp would wrap its in-use counter. Return pieces are sent with idle gaps, and the check after the third piece catches a design that counts idle cycles or applies a message early. A configuration write to a busy lane, and a grant and a return on one lane in the same cycle, look for a design that applies the allowance at the wrong time or loses one of two updates to the same counter.

// File: rtl/vlcm_pkg.sv
package vlcm_pkg;

    // Return message layout: lane index above, credit count below.
    localparam int MSG_W   = 8;
    localparam int PIECE_W = 2;
    localparam int PIECES  = MSG_W / PIECE_W;
    localparam int RVL_W   = 5;
    localparam int RCNT_W  = 3;

    typedef struct packed {
        logic [RVL_W-1:0]  vl;
        logic [RCNT_W-1:0] cnt;
    } ret_msg_t;

endpackage

// File: rtl/vlcm_ret_asm.sv
module vlcm_ret_asm
    import vlcm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ltp_valid,
    input  logic [PIECE_W-1:0] ltp_crd,
    output logic               ret_valid,
    output ret_msg_t           ret
);
    localparam int PH_W = $clog2(PIECES);

    logic [PH_W-1:0]               phase;
    logic [MSG_W-PIECE_W-1:0]      hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            hold  <= '0;
        end else if (ltp_valid) begin
            phase <= phase + 1'b1;
            hold  <= {hold[MSG_W-2*PIECE_W-1:0], ltp_crd};
        end
    end

    // The fourth piece completes the message; it is used straight away.
    assign ret       = ret_msg_t'({hold, ltp_crd});
    assign ret_valid = ltp_valid && (phase == PH_W'(PIECES-1));

    p_phase_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ltp_valid |=> $stable(phase));

endmodule

// File: rtl/vlcm_slot.sv
module vlcm_slot
    import vlcm_pkg::*;
#(
    parameter int DED_W    = 8,
    parameter int SHR_W    = 10,
    parameter int REQ_W    = 3,
    parameter int DED_INIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REQ_W-1:0]  take_ded,
    input  logic [REQ_W-1:0]  take_shr,
    input  logic [RCNT_W-1:0] ret_ded,
    input  logic [RCNT_W-1:0] ret_shr,
    input  logic              cfg_we,
    input  logic [DED_W-1:0]  cfg_val,
    output logic [DED_W-1:0]  used,
    output logic [SHR_W-1:0]  borrowed,
    output logic [DED_W-1:0]  limit,
    output logic              pend
);
    logic [DED_W-1:0] pend_val;
    logic             can_apply;

    assign can_apply = (used == '0) && (borrowed == '0) &&
                       (take_ded == '0) && (take_shr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            used     <= '0;
            borrowed <= '0;
            limit    <= DED_W'(DED_INIT);
            pend     <= 1'b0;
            pend_val <= '0;
        end else begin
            used     <= used + DED_W'(take_ded) - DED_W'(ret_ded);
            borrowed <= borrowed + SHR_W'(take_shr) - SHR_W'(ret_shr);
            if (cfg_we) begin
                pend_val <= cfg_val;
                if (can_apply) begin
                    limit <= cfg_val;
                    pend  <= 1'b0;
                end else begin
                    pend  <= 1'b1;
                end
            end else if (pend && can_apply) begin
                limit <= pend_val;
                pend  <= 1'b0;
            end
        end
    end

    p_ded_bound_r2: assert property (@(posedge clk) disable iff (rst)
        used <= limit);

    p_cfg_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(limit) |-> ($past(used) == '0 && $past(borrowed) == '0));

endmodule

// File: rtl/vl_credit_mgr.sv
module vl_credit_mgr
    import vlcm_pkg::*;
#(
    parameter int NUM_VL      = 32,
    parameter int DED_W       = 8,
    parameter int SHR_W       = 10,
    parameter int REQ_W       = 3,
    parameter int DED_INIT    = 4,
    parameter int SHR_CREDITS = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [$clog2(NUM_VL)-1:0]  req_vl,
    input  logic [REQ_W-1:0]           req_flits,
    output logic                       gnt,
    output logic [DED_W-1:0]           req_ded_free,
    output logic [SHR_W-1:0]           shared_free,
    input  logic                       ltp_valid,
    input  logic [PIECE_W-1:0]         ltp_crd,
    input  logic                       cfg_valid,
    input  logic [$clog2(NUM_VL)-1:0]  cfg_vl,
    input  logic [DED_W-1:0]           cfg_ded,
    output logic [NUM_VL-1:0]          cfg_pend
);
    localparam int VL_W = $clog2(NUM_VL);

    logic [DED_W-1:0] used_a   [NUM_VL];
    logic [SHR_W-1:0] bor_a    [NUM_VL];
    logic [DED_W-1:0] limit_a  [NUM_VL];

    // Return message assembly
    logic     ret_valid;
    ret_msg_t ret;

    vlcm_ret_asm u_asm (
        .clk       (clk),
        .rst       (rst),
        .ltp_valid (ltp_valid),
        .ltp_crd   (ltp_crd),
        .ret_valid (ret_valid),
        .ret       (ret)
    );

    // Grant decision: private credit first, then the common region
    logic [REQ_W-1:0] take_d, need_s;
    logic             vl_ok;

    assign vl_ok        = (int'(req_vl) < NUM_VL);
    assign req_ded_free = limit_a[req_vl] - used_a[req_vl];
    assign take_d       = (req_ded_free >= DED_W'(req_flits)) ? req_flits
                                                              : req_ded_free[REQ_W-1:0];
    assign need_s       = req_flits - take_d;
    assign gnt          = req_valid && vl_ok && (SHR_W'(need_s) <= shared_free);

    // Return split: repay borrowed credit first, then private credit
    logic [VL_W-1:0]   rv;
    logic              ret_ok;
    logic [RCNT_W-1:0] r_s, r_rem, r_d;

    assign rv     = VL_W'(ret.vl);
    assign ret_ok = ret_valid && (int'(ret.vl) < NUM_VL);
    assign r_s    = (SHR_W'(ret.cnt) <= bor_a[rv]) ? ret.cnt : bor_a[rv][RCNT_W-1:0];
    assign r_rem  = ret.cnt - r_s;
    assign r_d    = (DED_W'(r_rem) <= used_a[rv]) ? r_rem : used_a[rv][RCNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            shared_free <= SHR_W'(SHR_CREDITS);
        end else begin
            shared_free <= shared_free - SHR_W'(gnt ? need_s : '0)
                                       + SHR_W'(ret_ok ? r_s : '0);
        end
    end

    for (genvar g = 0; g < NUM_VL; g++) begin : g_slot
        logic hit_req, hit_ret;
        assign hit_req = gnt && (int'(req_vl) == g);
        assign hit_ret = ret_ok && (int'(rv) == g);

        vlcm_slot #(
            .DED_W    (DED_W),
            .SHR_W    (SHR_W),
            .REQ_W    (REQ_W),
            .DED_INIT (DED_INIT)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .take_ded (hit_req ? take_d : '0),
            .take_shr (hit_req ? need_s : '0),
            .ret_ded  (hit_ret ? r_d : '0),
            .ret_shr  (hit_ret ? r_s : '0),
            .cfg_we   (cfg_valid && (int'(cfg_vl) == g)),
            .cfg_val  (cfg_ded),
            .used     (used_a[g]),
            .borrowed (bor_a[g]),
            .limit    (limit_a[g]),
            .pend     (cfg_pend[g])
        );
    end

    // Common-region conservation: free plus all borrowed equals the size
    logic [SHR_W+VL_W:0] bor_sum;
    always_comb begin
        bor_sum = '0;
        for (int i = 0; i < NUM_VL; i++) bor_sum += (SHR_W+VL_W+1)'(bor_a[i]);
    end

    p_pool_conserve_r3: assert property (@(posedge clk) disable iff (rst)
        bor_sum + (SHR_W+VL_W+1)'(shared_free) == (SHR_W+VL_W+1)'(SHR_CREDITS));

    p_refuse_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !gnt && !ret_valid) |=> $stable(shared_free));

endmodule

// File: tb/tb_vl_credit_mgr.sv
module tb_vl_credit_mgr;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [4:0] req_vl;
    logic [2:0] req_flits;
    logic       gnt;
    logic [7:0] req_ded_free;
    logic [9:0] shared_free;
    logic       ltp_valid;
    logic [1:0] ltp_crd;
    logic       cfg_valid;
    logic [4:0] cfg_vl;
    logic [7:0] cfg_ded;
    logic [31:0] cfg_pend;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vl_credit_mgr dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vl(req_vl),
        .req_flits(req_flits), .gnt(gnt), .req_ded_free(req_ded_free),
        .shared_free(shared_free), .ltp_valid(ltp_valid), .ltp_crd(ltp_crd),
        .cfg_valid(cfg_valid), .cfg_vl(cfg_vl), .cfg_ded(cfg_ded),
        .cfg_pend(cfg_pend)
    );

    // {req tag 4, op 2 (0 request, 1 return), lane 5, n 3, gnt 1, private free 8, shared 10}
    localparam logic [32:0] TBL [12] = '{
        {4'd2,  2'd0, 5'd1, 3'd3, 1'b1, 8'd1, 10'd16},  // R2
        {4'd3,  2'd0, 5'd1, 3'd3, 1'b1, 8'd0, 10'd14},  // R3 spill
        {4'd3,  2'd0, 5'd2, 3'd7, 1'b1, 8'd0, 10'd11},  // R3
        {4'd3,  2'd0, 5'd1, 3'd7, 1'b1, 8'd0, 10'd4},   // R3 all shared
        {4'd4,  2'd0, 5'd2, 3'd5, 1'b0, 8'd0, 10'd4},   // R4 refusal
        {4'd6,  2'd1, 5'd1, 3'd5, 1'b0, 8'd0, 10'd9},   // R6 repay only
        {4'd6,  2'd1, 5'd1, 3'd7, 1'b0, 8'd3, 10'd13},  // R6 straddle
        {4'd6,  2'd1, 5'd1, 3'd7, 1'b0, 8'd4, 10'd13},  // R6 excess dropped
        {4'd2,  2'd0, 5'd3, 3'd4, 1'b1, 8'd0, 10'd13},  // R2
        {4'd6,  2'd1, 5'd2, 3'd3, 1'b0, 8'd0, 10'd16},  // R6
        {4'd6,  2'd1, 5'd2, 3'd4, 1'b0, 8'd4, 10'd16},  // R6
        {4'd5,  2'd1, 5'd3, 3'd4, 1'b0, 8'd4, 10'd16}   // R5
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_req(input logic [4:0] vl, input logic [2:0] n, output logic g);
        req_valid = 1'b1; req_vl = vl; req_flits = n;
        #1 g = gnt;
        tick();
        req_valid = 1'b0;
        #1;
    endtask

    task automatic piece(input logic [1:0] bits);
        ltp_valid = 1'b1; ltp_crd = bits;
        tick();
        ltp_valid = 1'b0;
    endtask

    task automatic send_ret(input logic [4:0] vl, input logic [2:0] cnt, input bit gap);
        logic [7:0] m;
        m = {vl, cnt};
        for (int i = 0; i < 4; i++) begin
            piece(m[7-2*i -: 2]);
            if (gap) begin ltp_crd = 2'b11; tick(); end
        end
        #1;
    endtask

    task automatic peek(input logic [4:0] vl);
        req_vl = vl;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 act=timeout exp=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic g;
        logic [7:0] m;
        rst = 1'b1; req_valid = 0; req_vl = 0; req_flits = 0;
        ltp_valid = 0; ltp_crd = 0; cfg_valid = 0; cfg_vl = 0; cfg_ded = 0;
        repeat (3) tick();
        rst = 1'b0;
        #1;

        // R1 reset state
        peek(5'd0);  chk("R1 ded lane0", req_ded_free, 4);
        peek(5'd31); chk("R1 ded lane31", req_ded_free, 4);
        chk("R1 shared", shared_free, 16);
        chk("R1 pend", cfg_pend, 0);
        chk("R1 gnt", gnt, 0);

        // Vector table
        for (int k = 0; k < 12; k++) begin
            logic [32:0] e;
            string t;
            e = TBL[k];
            t = $sformatf("R%0d row%0d", e[32:29], k);
            if (e[28:27] == 2'd0) begin
                do_req(e[26:22], e[21:19], g);
                chk({t, " gnt"}, g, e[18]);
            end else begin
                send_ret(e[26:22], e[21:19], 1'b0);
            end
            peek(e[26:22]);
            chk({t, " ded"}, req_ded_free, e[17:10]);
            chk({t, " shared"}, shared_free, e[9:0]);
        end
        // R10: lane 1 untouched by activity on lanes 2 and 3
        peek(5'd1); chk("R10 lane1 ded", req_ded_free, 4);
        peek(5'd4); chk("R10 lane4 ded", req_ded_free, 4);

        // R7 idle reconfiguration
        cfg_valid = 1; cfg_vl = 5'd5; cfg_ded = 8'd9;
        tick(); cfg_valid = 0;
        peek(5'd5);
        chk("R7 ded", req_ded_free, 9);
        chk("R7 pend", cfg_pend[5], 0);

        // R8 busy reconfiguration
        do_req(5'd6, 3'd2, g);
        cfg_valid = 1; cfg_vl = 5'd6; cfg_ded = 8'd6;
        tick(); cfg_valid = 0;
        peek(5'd6);
        chk("R8 old limit", req_ded_free, 2);
        chk("R8 pend set", cfg_pend[6], 1);
        send_ret(5'd6, 3'd2, 1'b0);
        peek(5'd6);
        chk("R8 drained old limit", req_ded_free, 4);
        chk("R8 still pend", cfg_pend[6], 1);
        tick(); #1;
        chk("R8 new limit", req_ded_free, 6);
        chk("R8 pend clear", cfg_pend[6], 0);

        // R9 grant and return on one lane in one cycle
        do_req(5'd7, 3'd3, g);
        m = {5'd7, 3'd2};
        piece(m[7:6]); piece(m[5:4]); piece(m[3:2]);
        ltp_valid = 1; ltp_crd = m[1:0];
        req_valid = 1; req_vl = 5'd7; req_flits = 3'd2;
        #1 chk("R9 gnt", gnt, 1);
        tick();
        ltp_valid = 0; req_valid = 0;
        #1;
        chk("R9 ded", req_ded_free, 2);
        chk("R9 shared", shared_free, 15);

        // R5 pieces with idle gaps, message held until the fourth piece
        do_req(5'd8, 3'd4, g);
        m = {5'd8, 3'd3};
        piece(m[7:6]); ltp_crd = 2'b11; tick();
        piece(m[5:4]); ltp_crd = 2'b11; tick();
        piece(m[3:2]); ltp_crd = 2'b11; tick();
        peek(5'd8);
        chk("R5 not early", req_ded_free, 0);
        piece(m[1:0]);
        #1 chk("R5 applied", req_ded_free, 3);

        // R5 highest lane index field
        do_req(5'd31, 3'd1, g);
        send_ret(5'd31, 3'd1, 1'b1);
        peek(5'd31);
        chk("R5 lane31", req_ded_free, 4);
        chk("R6 shared end", shared_free, 15);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule